// File: doc/BRIEF.md
# Character Cell Pixel Row Fetch with Cursor Overlay

This block turns a character code and a pixel row index into the five dots of that row inside one character cell. It is used by the display scan path. For each cell and row the scan logic presents the code read from display memory, the row being scanned and whether the cell sits at the edit position. The block returns the row pattern one clock later. Low codes come from a small writable glyph store that the host fills with its own symbols. All other codes come from a fixed pattern table. Here that table is a computed stub in place of real font artwork.

Two cursor styles are laid over the pattern. An underline lights the whole bottom row of the cell. A blink swaps the whole cell with a solid block on alternate 32-frame periods, and a frame tick input paces it. The cursor shows only when the edit position points into display memory. When the edit position points into the glyph store, both cursor styles are held off.

Top module: `glyph_row_fetch`

## Requirements
- R1: A synchronous active-high reset clears the output row to 5'b00000, clears the frame count and the blink phase to 0, and clears every glyph store entry to 5'b00000.
- R2: When code bits 7:4 are all zero, the output is the glyph store entry at the 7-bit address {code[3:0], row}. An entry is written at a rising clock edge while `store_we` is high, with `store_wdata` placed at `store_waddr` in that same address layout. Bit 4 of a row is the leftmost dot, and a 1 is a lit dot.
- R3: For any other code, the output is the fixed stub pattern code[4:0] XOR {row[2:0], row[1:0]}.
- R4: The output is registered. Inputs present before a rising edge show at `pix_row` after that edge, and each cycle's inputs give an independent result.
- R5: The cursor is active only when `cur_here` is 1 and `ac_in_glyph` is 0. While `ac_in_glyph` is 1, neither cursor style changes the output.
- R6: With the cursor active and `underline_en` set, row 7 is the stored row 7 ORed with 5'b11111. The other rows are unchanged. With no active cursor, row 7 shows its stored data.
- R7: The blink phase starts at 0 and toggles on every 32nd frame tick. While the phase is 1, `blink_en` is set and the cursor is active, every row of the cell reads 5'b11111. While the phase is 0, the cell shows its normal pattern.
- R8: Underline and blink may be enabled together. In blink phase 0, only the underline shows. In phase 1, the whole cell is solid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_code | input | 8 | Character code of the cell |
| row_idx | input | 3 | Pixel row within the cell, 7 is the cursor row |
| cur_here | input | 1 | Cell matches the edit position |
| ac_in_glyph | input | 1 | Edit position points into the glyph store |
| underline_en | input | 1 | Underline cursor enable |
| blink_en | input | 1 | Blink cursor enable |
| frame_tick | input | 1 | One-cycle pulse per display frame |
| store_we | input | 1 | Glyph store write enable |
| store_waddr | input | 7 | Glyph store write address {char[3:0], row} |
| store_wdata | input | 5 | Glyph store write data, bit 4 leftmost |
| pix_row | output | 5 | Registered pixel row, bit 4 leftmost |

## Verification
A wrong source select or a wrong address split shows up one cycle later as a row that differs from the reference pattern for that code. The bench covers low codes, high codes and every row of a stored glyph. A frame counter that is off by even one tick would move the first solid-block cycle. So the bench checks the cell just before and just after the 32nd and 64th ticks. A cursor gate that leaks while the edit position is in the glyph store, or while the cell does not match, shows as a lit bottom row or a solid cell on the next clock.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    localparam int unsigned CODE_W       = 8;
    localparam int unsigned ROW_IDX_W    = 3;
    localparam int unsigned COL_W        = 5;
    localparam int unsigned USER_CHARS   = 16;
    localparam int unsigned BLINK_FRAMES = 32;
    localparam int unsigned USER_SEL_W   = $clog2(USER_CHARS);
    localparam int unsigned STORE_AW     = USER_SEL_W + ROW_IDX_W;
    localparam int unsigned CURSOR_ROW   = (1 << ROW_IDX_W) - 1;

    typedef logic [COL_W-1:0]     pix_t;
    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [ROW_IDX_W-1:0] row_t;
    typedef logic [STORE_AW-1:0]  saddr_t;

    typedef enum logic {
        SRC_STORE = 1'b0,
        SRC_TABLE = 1'b1
    } src_e;

    typedef struct packed {
        code_t code;
        row_t  row;
    } fetch_req_t;

    typedef struct packed {
        logic active;
        logic underline;
        logic blink;
    } cursor_ctl_t;

    function automatic src_e pick_source(input code_t code);
        return (code[CODE_W-1:USER_SEL_W] == '0) ? SRC_STORE : SRC_TABLE;
    endfunction

    function automatic saddr_t store_addr(input code_t code, input row_t row);
        return {code[USER_SEL_W-1:0], row};
    endfunction

    function automatic pix_t table_row(input code_t code, input row_t row);
        pix_t mix;
        mix = {row, row[1:0]};
        return code[COL_W-1:0] ^ mix;
    endfunction

endpackage

// File: rtl/glyph_user_store.sv
module glyph_user_store
    import glyph_pkg::*;
#(
    parameter int unsigned AW = STORE_AW,
    parameter int unsigned DW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R2: a write is visible at its address on the following cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/glyph_blink_timer.sv
module glyph_blink_timer #(
    parameter int unsigned PERIOD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic phase
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          wrap;

    assign wrap = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            cnt_q   <= wrap ? '0 : cnt_q + 1'b1;
            phase_q <= phase_q ^ wrap;
        end
    end

    assign phase = phase_q;

    // R7: the count holds between frame ticks
    a_r7_count_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R7: the phase changes only right after a tick
    a_r7_phase_on_tick: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> $past(tick));

    // R1: reset clears count and phase
    a_r1_timer_reset: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !phase_q));

endmodule

// File: rtl/glyph_cursor_merge.sv
module glyph_cursor_merge
    import glyph_pkg::*;
(
    input  pix_t        base,
    input  row_t        row,
    input  cursor_ctl_t ctl,
    input  logic        phase,
    output pix_t        merged
);
    localparam pix_t SOLID = '1;

    logic on_cursor_row;
    logic show_block;
    logic show_line;

    assign on_cursor_row = (row == ROW_IDX_W'(CURSOR_ROW));
    assign show_block    = ctl.active && ctl.blink && phase;
    assign show_line     = ctl.active && ctl.underline && on_cursor_row;

    always_comb begin
        if (show_block) begin
            merged = SOLID;
        end else if (show_line) begin
            merged = base | SOLID;
        end else begin
            merged = base;
        end
    end

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
    import glyph_pkg::*;
#(
    parameter int unsigned BLINK_PERIOD = BLINK_FRAMES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CODE_W-1:0]    char_code,
    input  logic [ROW_IDX_W-1:0] row_idx,
    input  logic                 cur_here,
    input  logic                 ac_in_glyph,
    input  logic                 underline_en,
    input  logic                 blink_en,
    input  logic                 frame_tick,
    input  logic                 store_we,
    input  logic [STORE_AW-1:0]  store_waddr,
    input  logic [COL_W-1:0]     store_wdata,
    output logic [COL_W-1:0]     pix_row
);
    fetch_req_t  req;
    cursor_ctl_t ctl;
    src_e        src;
    pix_t        store_row;
    pix_t        base_row;
    pix_t        merged_row;
    pix_t        pix_q;
    logic        blink_phase;

    assign req.code = char_code;
    assign req.row  = row_idx;
    assign src      = pick_source(req.code);

    assign ctl.active    = cur_here && !ac_in_glyph;
    assign ctl.underline = underline_en;
    assign ctl.blink     = blink_en;

    glyph_user_store #(
        .AW (STORE_AW),
        .DW (COL_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .waddr (store_waddr),
        .wdata (store_wdata),
        .raddr (store_addr(req.code, req.row)),
        .rdata (store_row)
    );

    assign base_row = (src == SRC_STORE) ? store_row : table_row(req.code, req.row);

    glyph_blink_timer #(
        .PERIOD (BLINK_PERIOD)
    ) u_blink (
        .clk   (clk),
        .rst   (rst),
        .tick  (frame_tick),
        .phase (blink_phase)
    );

    glyph_cursor_merge u_merge (
        .base   (base_row),
        .row    (req.row),
        .ctl    (ctl),
        .phase  (blink_phase),
        .merged (merged_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else begin
            pix_q <= merged_row;
        end
    end

    assign pix_row = pix_q;

    // R1: output cleared after reset
    a_r1_out_reset: assert property (@(posedge clk)
        rst |=> (pix_row == '0));

    // R5: no cursor effect while the edit position is in the glyph store
    a_r5_glyph_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        ac_in_glyph |=> (pix_row == $past(base_row)));

    // R5: a cell away from the edit position is never altered
    a_r5_no_match_quiet: assert property (@(posedge clk) disable iff (rst)
        !cur_here |=> (pix_row == $past(base_row)));

    // R6: underline lights the full cursor row
    a_r6_underline_full: assert property (@(posedge clk) disable iff (rst)
        (cur_here && !ac_in_glyph && underline_en && row_idx == ROW_IDX_W'(CURSOR_ROW))
        |=> (pix_row == '1));

endmodule

// File: tb/glyph_row_fetch_tb.sv
module glyph_row_fetch_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] char_code = '0;
    logic [2:0] row_idx = '0;
    logic       cur_here = 1'b0;
    logic       ac_in_glyph = 1'b0;
    logic       underline_en = 1'b0;
    logic       blink_en = 1'b0;
    logic       frame_tick = 1'b0;
    logic       store_we = 1'b0;
    logic [6:0] store_waddr = '0;
    logic [4:0] store_wdata = '0;
    logic [4:0] pix_row;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_total = 0;
    logic [4:0] shadow [128];

    logic [4:0] exp_q [$];
    int         due_q [$];
    string      tag_q [$];

    glyph_row_fetch u_dut (
        .clk (clk), .rst (rst), .char_code (char_code), .row_idx (row_idx),
        .cur_here (cur_here), .ac_in_glyph (ac_in_glyph),
        .underline_en (underline_en), .blink_en (blink_en),
        .frame_tick (frame_tick), .store_we (store_we),
        .store_waddr (store_waddr), .store_wdata (store_wdata),
        .pix_row (pix_row)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] model(input logic [7:0] c, input logic [2:0] r,
                                         input logic m, input logic g,
                                         input logic ul, input logic bl);
        logic [4:0] b;
        logic act;
        logic ph;
        b   = (c[7:4] == 4'h0) ? shadow[{c[3:0], r}] : (c[4:0] ^ {r, r[1:0]});
        act = m && !g;
        ph  = ((tick_total / 32) % 2) == 1;
        if (bl && act && ph) return 5'b11111;
        if (ul && act && r == 3'd7) return b | 5'b11111;
        return b;
    endfunction

    task automatic step(input logic [7:0] c, input logic [2:0] r, input logic m,
                        input logic g, input logic ul, input logic bl, input string tag);
        @(negedge clk);
        char_code = c; row_idx = r; cur_here = m; ac_in_glyph = g;
        underline_en = ul; blink_en = bl;
        exp_q.push_back(model(c, r, m, g, ul, bl));
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    task automatic write_store(input logic [6:0] a, input logic [4:0] d);
        @(negedge clk);
        store_we = 1'b1; store_waddr = a; store_wdata = d;
        @(negedge clk);
        store_we = 1'b0;
        shadow[a] = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1'b1;
        end
        @(negedge clk);
        frame_tick = 1'b0;
        tick_total += n;
    endtask

    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            checks++;
            if (pix_row !== exp_q[0]) begin
                errors++;
                $display("FAIL %s: got %b expected %b", tag_q[0], pix_row, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 5'b00000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (pix_row !== 5'b00000) begin
            errors++;
            $display("FAIL R1 reset output: got %b expected %b", pix_row, 5'b00000);
        end
        // R1: glyph store reads zero after reset
        step(8'h00, 3'd3, 0, 0, 0, 0, "R1 cleared store");
        step(8'h0F, 3'd7, 0, 0, 0, 0, "R1 cleared store row 7");

        // R2: fill a glyph and read every row back
        for (int r = 0; r < 8; r++) write_store({4'h5, 3'(r)}, 5'(r * 3 + 1));
        write_store({4'hF, 3'd7}, 5'b10101);
        write_store({4'h0, 3'd2}, 5'b10000);
        for (int r = 0; r < 8; r++) step(8'h05, 3'(r), 0, 0, 0, 0, "R2 store glyph 5");
        step(8'h00, 3'd2, 0, 0, 0, 0, "R2 leftmost dot");
        step(8'h0F, 3'd7, 0, 0, 0, 0, "R2 store glyph 15 row 7");

        // R3: table codes, R4 back-to-back each cycle
        step(8'h10, 3'd0, 0, 0, 0, 0, "R3 table 0x10");
        step(8'h41, 3'd5, 0, 0, 0, 0, "R3 table 0x41");
        step(8'hFF, 3'd7, 0, 0, 0, 0, "R3 table 0xFF");
        step(8'h15, 3'd2, 0, 0, 0, 0, "R4 alternate table");
        step(8'h05, 3'd2, 0, 0, 0, 0, "R4 alternate store");

        // R5: suppression in glyph mode and when not matching
        step(8'h0F, 3'd7, 1, 1, 1, 0, "R5 glyph mode suppress");
        step(8'h41, 3'd7, 0, 0, 1, 0, "R5 no match");
        // R6: underline
        step(8'h0F, 3'd7, 1, 0, 1, 0, "R6 underline row 7");
        step(8'h41, 3'd3, 1, 0, 1, 0, "R6 underline other row");
        step(8'h0F, 3'd7, 1, 0, 0, 0, "R6 cursor off row 7");

        // R7: blink timing
        step(8'h41, 3'd2, 1, 0, 0, 1, "R7 phase 0 normal");
        ticks(31);
        step(8'h41, 3'd2, 1, 0, 0, 1, "R7 31 ticks normal");
        ticks(1);
        step(8'h41, 3'd2, 1, 0, 0, 1, "R7 32 ticks solid");
        step(8'h05, 3'd0, 1, 0, 0, 1, "R7 solid store code");
        step(8'h41, 3'd2, 0, 0, 0, 1, "R7 no match no blink");
        step(8'h41, 3'd2, 1, 1, 0, 1, "R5 glyph mode no blink");
        // R8: both styles in phase 1
        step(8'h41, 3'd2, 1, 0, 1, 1, "R8 both phase 1");
        ticks(31);
        step(8'h41, 3'd2, 1, 0, 0, 1, "R7 63 ticks solid");
        ticks(1);
        step(8'h41, 3'd2, 1, 0, 0, 1, "R7 64 ticks normal");
        // R8: both styles in phase 0
        step(8'h41, 3'd7, 1, 0, 1, 1, "R8 both phase 0 row 7");
        step(8'h41, 3'd2, 1, 0, 1, 1, "R8 both phase 0 row 2");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule